// File: doc/BRIEF.md
# Configurable Parallel Bus Master

This block turns host read and write requests into transactions on a simple external parallel bus for programmable-logic targets. Each transaction is built from bus cycles. A bus cycle lasts `2*(div+1)` system clocks: the output clock is low for the first half of the cycle and high for the second half. The output clock can be switched off, left free running, or gated so that it toggles only while a transaction is in progress. A frame marker flags the first transaction of each group of transactions. An optional ready input from the target can stretch the strobe phase, and a wait limit ends the transaction with an error if ready never arrives.

A 24-bit configuration word holds every option. It is written only while the mode input is zero. Any change of the mode input clears it to all zeros, so software must write it again after each mode change. The host hands over one request at a time with a valid/ready handshake. Each request completes with a one-clock response pulse that carries an error flag and, for reads, the returned data.

Configuration layout:

| Bits | Field |
|---|---|
| [0] | clock output enable |
| [1] | clock gating |
| [2] | ready enable |
| [3] | split write phases |
| [5:4] | data size: 0 = 8, 1 = 16, 2 = 24, 3 = 32 bits |
| [7:6] | address size: 0 = none, 1 = 8, 2 = 16, 3 = 24 bits |
| [11:8] | frame count |
| [19:12] | wait limit |
| [23:20] | divider |

Top module: `gpbus_master`

## Requirements
- R1: A configuration write whose data-size field is 3 (32 bits) stores the clock output enable as 0, so `bus_clk_o` stays low.
- R2: Any change of `mode_sel` clears the configuration to zero on the next clock. Configuration writes and requests are accepted only while `mode_sel` is 0.
- R3: A bus cycle lasts `2*(div+1)` clocks. While the output clock is active, it is low for the first `div+1` clocks and high for the last `div+1` clocks.
- R4: While the clock output enable is 0, `bus_clk_o` is held low.
- R5: When gating is set and `div` is nonzero, `bus_clk_o` stays low while idle and toggles only during a transaction. When `div` is 0, gating has no effect and the clock runs freely.
- R6: An unsplit write uses one strobe cycle carrying both address and data. A split write uses an address cycle with no strobe, then a data cycle with `bus_wr_o` high. `bus_rd_o` and `bus_wr_o` are never high together.
- R7: A read always uses an address cycle followed by a strobe cycle. Data is sampled on the last clock of the strobe cycle and returned with `rsp_valid` high for exactly one clock, on the clock after completion.
- R8: With ready enabled, `bus_rdy_i` is sampled on the last clock of each strobe cycle. A low sample adds another strobe cycle.
- R9: After wait-limit extra strobe cycles with ready still low, the transaction ends with `rsp_err` set and zero read data.
- R10: Only the low `8*asize` address bits reach `bus_addr_o`. With address size 0, no address is driven.
- R11: Write data and returned read data are masked to the selected data width.
- R12: `bus_frame_o` is high during the first transaction of each frame of `framecount+1` transactions. Any configuration load restarts the frame.
- R13: `req_ready` is high only when the block is idle, `mode_sel` is 0 and the current bus cycle is on its last clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode; 0 selects this bus mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request address |
| req_wdata | input | 32 | Request write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Wait-limit timeout |
| rsp_rdata | output | 32 | Read data |
| bus_clk_o | output | 1 | External bus clock |
| bus_frame_o | output | 1 | Frame marker |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_addr_o | output | 24 | Bus address |
| bus_data_o | output | 32 | Bus write data |
| bus_data_oe | output | 1 | Write data drive enable |
| bus_data_i | input | 32 | Bus read data |
| bus_rdy_i | input | 1 | Target ready |

## Verification
The hardest case to reach from the ports is the timeout. The target must keep ready low across an exact number of strobe-cycle boundaries, and those boundaries fall only on the last clock of each divided bus cycle. The bench drives ready from a counter of strobe clocks, which places the ready edge before or after a chosen boundary. It then checks both the stretched strobe length and the error flag. A reference model tracks the divider phase clock by clock, so request acceptance, which is allowed only on a cycle's last clock, is also checked under gated and free-running clocks.

// File: rtl/gpbus_pkg.sv
`timescale 1ns/1ps
package gpbus_pkg;
    localparam int DIV_W  = 4;
    localparam int WAIT_W = 8;
    localparam int FRM_W  = 4;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam logic [1:0] DSZ_32 = 2'd3;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [WAIT_W-1:0] max_wait;
        logic [FRM_W-1:0]  frm_cnt;
        logic [1:0]        asize;
        logic [1:0]        dsize;
        logic              wr_split;
        logic              rdy_en;
        logic              clk_gate;
        logic              clk_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2
    } st_e;

    function automatic logic [DATA_W-1:0] dmask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] amask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 24'h00_0000;
            2'd1:    return 24'h00_00FF;
            2'd2:    return 24'h00_FFFF;
            default: return 24'hFF_FFFF;
        endcase
    endfunction

    function automatic cfg_t sanitize(input cfg_t c);
        cfg_t r;
        r = c;
        if (r.dsize == DSZ_32) r.clk_en = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/gpbus_cfg.sv
`timescale 1ns/1ps
module gpbus_cfg
    import gpbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cfg_t             cfg,
    output logic             cfg_load
);
    logic [1:0] mode_q;
    logic       mode_chg;

    assign mode_chg = (mode_sel != mode_q);
    assign cfg_load = mode_chg | (cfg_we & (mode_sel == 2'd0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            mode_q <= '0;
        end else begin
            mode_q <= mode_sel;
            if (mode_chg)
                cfg <= '0;
            else if (cfg_we && mode_sel == 2'd0)
                cfg <= sanitize(cfg_t'(cfg_wdata));
        end
    end

    // R2: a mode change wipes the whole configuration
    p_mode_wipe_r2: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (cfg == '0));

    // R1: a 32-bit data size never coexists with the clock output
    p_no_clk32_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg.dsize == DSZ_32) |-> !cfg.clk_en);
endmodule

// File: rtl/gpbus_clkgen.sv
`timescale 1ns/1ps
module gpbus_clkgen
    import gpbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             half,
    output logic             boundary
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = (cnt >= div);
    assign boundary = half & wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            half <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            half <= ~half;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R3: a new bus cycle always opens in its low half
    p_cycle_low_r3: assert property (@(posedge clk) disable iff (rst)
        boundary |=> !half);

    // R3: the phase holds until the divider count wraps
    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(half));
endmodule

// File: rtl/gpbus_seq.sv
`timescale 1ns/1ps
module gpbus_seq
    import gpbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              cfg_load,
    input  logic              mode_ok,
    input  logic              half,
    input  logic              boundary,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_clk_o,
    output logic              bus_frame_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              bus_rdy_i
);
    st_e               st;
    logic              is_wr, split_q, first_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WAIT_W-1:0] waits;
    logic [FRM_W-1:0]  frm_idx;
    logic              busy, stall, done, clk_free;

    assign busy      = (st != ST_IDLE);
    assign req_ready = (st == ST_IDLE) && mode_ok && boundary;
    assign stall     = cfg.rdy_en & ~bus_rdy_i;
    assign done      = (st == ST_STRB) && boundary && (!stall || waits == cfg.max_wait);
    assign clk_free  = !cfg.clk_gate || (cfg.div == '0);

    always_comb begin
        bus_clk_o   = cfg.clk_en && (clk_free || busy) && half;
        bus_frame_o = busy && first_q;
        bus_wr_o    = (st == ST_STRB) && is_wr;
        bus_rd_o    = (st == ST_STRB) && !is_wr;
        bus_data_oe = bus_wr_o;
        bus_data_o  = bus_wr_o ? wdata_q : '0;
        bus_addr_o  = ((st == ST_ADDR) || (bus_wr_o && !split_q)) ? addr_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            is_wr     <= 1'b0;
            split_q   <= 1'b0;
            first_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            waits     <= '0;
            frm_idx   <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        is_wr   <= req_write;
                        split_q <= cfg.wr_split;
                        first_q <= (frm_idx == '0);
                        addr_q  <= req_addr & amask(cfg.asize);
                        wdata_q <= req_wdata & dmask(cfg.dsize);
                        waits   <= '0;
                        st      <= (req_write && !cfg.wr_split) ? ST_STRB : ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (boundary) st <= ST_STRB;
                end
                ST_STRB: begin
                    if (done) begin
                        st        <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_err   <= stall;
                        rsp_rdata <= (!is_wr && !stall) ? (bus_data_i & dmask(cfg.dsize)) : '0;
                        frm_idx   <= (frm_idx >= cfg.frm_cnt) ? '0 : frm_idx + FRM_W'(1);
                    end else if (boundary) begin
                        waits <= waits + WAIT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
            if (cfg_load) frm_idx <= '0;
        end
    end

    // R6: read and write strobes are exclusive
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_o && bus_wr_o));

    // R7: a response is a single-clock pulse
    p_rsp_single_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R9: an error response only follows a strobe phase
    p_err_after_strb_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> $past(st == ST_STRB));

    // R12: the frame marker belongs to the first transaction of a frame
    p_frame_first_r12: assert property (@(posedge clk) disable iff (rst)
        bus_frame_o |-> (frm_idx == '0));

    // R13: no request is offered while a strobe is active
    p_ready_idle_r13: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_rd_o && !bus_wr_o));
endmodule

// File: rtl/gpbus_master.sv
`timescale 1ns/1ps
module gpbus_master
    import gpbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_clk_o,
    output logic              bus_frame_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              bus_rdy_i
);
    cfg_t cfg;
    logic cfg_load, half, boundary, mode_ok;

    assign mode_ok = (mode_sel == 2'd0);

    gpbus_cfg u_cfg (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg(cfg), .cfg_load(cfg_load)
    );

    gpbus_clkgen u_clkgen (
        .clk(clk), .rst(rst), .div(cfg.div), .half(half), .boundary(boundary)
    );

    gpbus_seq u_seq (
        .clk(clk), .rst(rst), .cfg(cfg), .cfg_load(cfg_load), .mode_ok(mode_ok),
        .half(half), .boundary(boundary),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_clk_o(bus_clk_o), .bus_frame_o(bus_frame_o), .bus_rd_o(bus_rd_o),
        .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
        .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i), .bus_rdy_i(bus_rdy_i)
    );
endmodule

// File: tb/gpbus_master_test.sv
`timescale 1ns/1ps
module gpbus_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        bus_clk_o, bus_frame_o, bus_rd_o, bus_wr_o, bus_data_oe;
    logic [23:0] bus_addr_o;
    logic [31:0] bus_data_o;
    logic [31:0] bus_data_i = '0;
    logic        bus_rdy_i = 1'b0;

    always #2.5 clk = ~clk;

    gpbus_master uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_clk_o(bus_clk_o), .bus_frame_o(bus_frame_o), .bus_rd_o(bus_rd_o),
        .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
        .bus_data_oe(bus_data_oe), .bus_data_i(bus_data_i), .bus_rdy_i(bus_rdy_i)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bdmask(input logic [1:0] sz);
        if (sz == 2'd3) return 32'hFFFF_FFFF;
        return (32'h1 << (8 * (int'(sz) + 1))) - 32'h1;
    endfunction

    function automatic logic [23:0] bamask(input logic [1:0] sz);
        logic [31:0] m;
        m = (32'h1 << (8 * int'(sz))) - 32'h1;
        return m[23:0];
    endfunction

    function automatic logic [23:0] mk(input bit ce, input bit gt, input bit re, input bit sp,
                                       input int ds, input int as, input int fc, input int mw, input int dv);
        logic [23:0] v;
        v = '0;
        v[0] = ce; v[1] = gt; v[2] = re; v[3] = sp;
        v[5:4] = 2'(ds); v[7:6] = 2'(as); v[11:8] = 4'(fc);
        v[19:12] = 8'(mw); v[23:20] = 4'(dv);
        return v;
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_cnt, m_st, m_waits, m_idx;
    logic        m_half, m_wr, m_split, m_first, m_rv, m_re;
    logic [31:0] m_rd, m_wd;
    logic [23:0] m_addr, m_cfg;
    logic [1:0]  m_mode;

    always @(posedge clk) begin : model
        int div;
        logic bnd, fin, ferr, load;
        logic [23:0] ncfg;
        if (rst) begin
            m_cnt = 0; m_st = 0; m_waits = 0; m_idx = 0;
            m_half = 0; m_wr = 0; m_split = 0; m_first = 0; m_rv = 0; m_re = 0;
            m_rd = 0; m_wd = 0; m_addr = 0; m_cfg = 0; m_mode = 0;
        end else begin
            div = int'(m_cfg[23:20]);
            bnd = m_half && (m_cnt >= div);
            m_rv = 0; fin = 0; ferr = 0;
            if (m_st == 0) begin
                if (bnd && mode_sel == 2'd0 && req_valid) begin
                    m_wr = req_write; m_split = m_cfg[3]; m_first = (m_idx == 0);
                    m_addr = req_addr & bamask(m_cfg[7:6]);
                    m_wd = req_wdata & bdmask(m_cfg[5:4]);
                    m_waits = 0;
                    m_st = (req_write && !m_cfg[3]) ? 2 : 1;
                end
            end else if (m_st == 1) begin
                if (bnd) m_st = 2;
            end else if (bnd) begin
                if (!(m_cfg[2] && !bus_rdy_i)) fin = 1;
                else if (m_waits == int'(m_cfg[19:12])) begin fin = 1; ferr = 1; end
                else m_waits++;
            end
            if (fin) begin
                m_st = 0; m_rv = 1; m_re = ferr;
                m_rd = (!m_wr && !ferr) ? (bus_data_i & bdmask(m_cfg[5:4])) : 32'h0;
                m_idx = (m_idx >= int'(m_cfg[11:8])) ? 0 : m_idx + 1;
            end
            if (m_cnt >= div) begin m_cnt = 0; m_half = !m_half; end
            else m_cnt++;
            load = 0; ncfg = m_cfg;
            if (mode_sel != m_mode) begin ncfg = 0; load = 1; m_mode = mode_sel; end
            else if (cfg_we && mode_sel == 2'd0) begin
                ncfg = cfg_wdata;
                if (ncfg[5:4] == 2'd3) ncfg[0] = 1'b0;
                load = 1;
            end
            m_cfg = ncfg;
            if (load) m_idx = 0;
        end
    end

    always @(negedge clk) begin : compare
        logic busy, free, e_wr, e_rd;
        #1;
        if (!rst) begin
            busy = (m_st != 0);
            free = !m_cfg[1] || (m_cfg[23:20] == 4'd0);
            e_wr = (m_st == 2) && m_wr;
            e_rd = (m_st == 2) && !m_wr;
            chk("R3 bus clock", {31'b0, bus_clk_o}, {31'b0, m_cfg[0] && (free || busy) && m_half});
            chk("R13 req_ready", {31'b0, req_ready},
                {31'b0, (m_st == 0) && (mode_sel == 2'd0) && m_half && (m_cnt >= int'(m_cfg[23:20]))});
            chk("R6 write strobe", {31'b0, bus_wr_o}, {31'b0, e_wr});
            chk("R7 read strobe", {31'b0, bus_rd_o}, {31'b0, e_rd});
            chk("R11 data drive", bus_data_o, e_wr ? m_wd : 32'h0);
            chk("R11 data enable", {31'b0, bus_data_oe}, {31'b0, e_wr});
            chk("R10 address", {8'b0, bus_addr_o},
                {8'b0, ((m_st == 1) || (e_wr && !m_split)) ? m_addr : 24'h0});
            chk("R12 frame", {31'b0, bus_frame_o}, {31'b0, busy && m_first});
            chk("R7 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rv});
            if (m_rv) begin
                chk("R9 rsp_err", {31'b0, rsp_err}, {31'b0, m_re});
                chk("R7 rsp_rdata", rsp_rdata, m_rd);
            end
        end
    end

    // ---------------- target side and monitors ----------------
    int rdy_hold = 0, scnt = 0, strb_len = 0, frm_rises = 0;
    logic [23:0] addr_or = '0;
    logic frm_prev = 0;

    always @(negedge clk) begin
        if (bus_rd_o || bus_wr_o) scnt = scnt + 1;
        else scnt = 0;
        bus_rdy_i = (scnt > rdy_hold);
    end

    always @(negedge clk) begin
        #1;
        if (bus_rd_o || bus_wr_o) strb_len++;
        if (bus_frame_o && !frm_prev) frm_rises++;
        frm_prev = bus_frame_o;
        addr_or = addr_or | bus_addr_o;
    end

    logic        last_err;
    logic [31:0] last_rd;

    task automatic cfg_write(input logic [23:0] v);
        @(negedge clk); cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic txn(input logic w, input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        strb_len = 0; addr_or = '0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk); req_valid = 1'b0;
        #1;
        while (!rsp_valid) begin @(negedge clk); #1; end
        last_err = rsp_err; last_rd = rsp_rdata;
    endtask

    task automatic count_hi(input int n, output int hi);
        hi = 0;
        repeat (n) begin @(negedge clk); #1; if (bus_clk_o) hi++; end
    endtask

    task automatic count_rdy(input int n, output int hi);
        hi = 0;
        repeat (n) begin @(negedge clk); #1; if (req_ready) hi++; end
    endtask

    initial begin
        int hi;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R4 clock low after reset", {31'b0, bus_clk_o}, 32'h0);

        // free running, div 1, 16-bit address and data
        cfg_write(mk(1, 0, 0, 0, 1, 2, 1, 0, 1));
        count_hi(16, hi);
        chk("R3 free-running duty", hi, 8);
        count_rdy(16, hi);
        chk("R13 ready once per bus cycle", hi, 4);
        txn(1'b1, 24'h123456, 32'hDEADBEEF);
        chk("R6 unsplit write strobe clocks", strb_len, 4);
        chk("R10 16-bit address", {8'b0, addr_or}, 32'h0000_3456);
        bus_data_i = 32'hCAFE_F00D;
        txn(1'b0, 24'h00ABCD, 32'h0);
        chk("R7 read strobe clocks", strb_len, 4);
        chk("R11 read data masked", last_rd, 32'h0000_F00D);

        // split writes, div 0, 24-bit address and data
        cfg_write(mk(1, 0, 0, 1, 2, 3, 0, 0, 0));
        txn(1'b1, 24'hFEDCBA, 32'h1122_3344);
        chk("R6 split write strobe clocks", strb_len, 2);

        // gated clock
        cfg_write(mk(1, 1, 0, 0, 1, 1, 0, 0, 2));
        count_hi(24, hi);
        chk("R5 gated clock idle low", hi, 0);
        txn(1'b1, 24'h000077, 32'h0000_5A5A);
        cfg_write(mk(1, 1, 0, 0, 1, 1, 0, 0, 0));
        count_hi(20, hi);
        chk("R5 gating ignored at zero divider", hi, 10);

        // clock output disabled
        cfg_write(mk(0, 0, 0, 0, 1, 1, 0, 0, 1));
        count_hi(16, hi);
        chk("R4 clock disabled", hi, 0);

        // ready stretch and timeout
        cfg_write(mk(1, 0, 1, 0, 0, 1, 0, 5, 1));
        rdy_hold = 6;
        bus_data_i = 32'h0000_00C3;
        txn(1'b0, 24'h000010, 32'h0);
        chk("R8 stretched strobe clocks", strb_len, 8);
        chk("R8 no error when ready arrives", {31'b0, last_err}, 32'h0);
        chk("R8 read data after stretch", last_rd, 32'h0000_00C3);
        cfg_write(mk(1, 0, 1, 0, 0, 1, 0, 2, 1));
        rdy_hold = 100;
        txn(1'b0, 24'h000011, 32'h0);
        chk("R9 timeout strobe clocks", strb_len, 12);
        chk("R9 timeout error", {31'b0, last_err}, 32'h1);
        chk("R9 timeout data zero", last_rd, 32'h0);
        rdy_hold = 0;

        // 32-bit data forces clock off
        cfg_write(mk(1, 0, 0, 0, 3, 0, 0, 0, 1));
        count_hi(16, hi);
        chk("R1 clock forced off at 32-bit", hi, 0);
        bus_data_i = 32'h89AB_CDEF;
        txn(1'b0, 24'hABCDEF, 32'h0);
        chk("R11 full-width read", last_rd, 32'h89AB_CDEF);
        chk("R10 no address driven", {8'b0, addr_or}, 32'h0);

        // frames of three transactions
        cfg_write(mk(1, 0, 0, 0, 0, 1, 2, 0, 0));
        frm_rises = 0;
        for (int i = 0; i < 6; i++) txn(1'b1, 24'(i), 32'(i));
        chk("R12 frame pulses", frm_rises, 2);

        // mode change wipes configuration
        cfg_write(mk(1, 0, 0, 0, 1, 1, 0, 0, 1));
        @(negedge clk); mode_sel = 2'd1;
        count_rdy(12, hi);
        chk("R2 no ready outside mode 0", hi, 0);
        cfg_write(mk(1, 0, 0, 0, 1, 1, 0, 0, 1));
        @(negedge clk); mode_sel = 2'd0;
        count_hi(16, hi);
        chk("R2 configuration wiped", hi, 0);
        txn(1'b1, 24'h000055, 32'h0000_00AA);
        chk("R2 default write one cycle", strb_len, 2);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule